// File: doc/BRIEF.md
# Keyed Dual-Core Stall Controller

This block holds two cores in a stalled state, or lets them run, under software control. A core is held only while its 8-bit stall key, kept as a 2-bit low field in the control word and a 6-bit high field in the key word, together equal 0x86. Any other value releases the core, including a value where only one of the two fields is right. Clearing either field is therefore enough to release the core. Because the two halves sit in different registers, one stray write cannot stall a core by accident.

Software reaches the block through a plain word-wide register bus. Each write replaces the whole word. There are no byte enables. Reads are combinational on the address. The control word also carries one self-clearing reset bit per core. Writing 1 to that bit sends a one-cycle reset pulse to that core.

Top module: `stall_key_ctrl`

## Requirements
- R1: After reset, both registers read zero, both stall outputs are low and both reset pulse outputs are low.
- R2: `stall_o[n]` is high in the cycle after the write that completes the key {high field, low field} == 0x86 for core n, and stays high while the key is unchanged.
- R3: For every key value other than 0x86, `stall_o[n]` is low. This includes values where only the low field (2) or only the high field (0x21) is right.
- R4: A write that puts zero into either key field of a stalled core makes that core's `stall_o` low from the next cycle on.
- R5: The key fields of each core sit at their own bit positions. Core n's low field is at bits [4n+1:4n] of word address 0. Core n's high field is at bits [8n+5:8n] of word address 1. Setting one core's key leaves the other core's stall output unchanged.
- R6: Writing 1 to bit 16+n of word address 0 drives `core_rst_o[n]` high for exactly the next cycle. That bit always reads back as 0.
- R7: Reads return the stored key fields at their write positions. All other bits read as 0.
- R8: Word addresses other than 0 and 1 read as zero, and writes to them change no stored state.
- R9: Every write replaces all fields of the addressed register, so any field left at 0 in the written data becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 4 | Word address used by writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| stall_o | output | 2 | Per-core stall request |
| core_rst_o | output | 2 | Per-core one-cycle reset pulse |

## Verification
On every cycle, the assertions check four things. Every reset pulse traces back to a write of its bit. A write that clears a key field drops that core's stall. Stall outputs do not move without a write. Unmapped writes leave the stored fields alone. Only the bench's scenarios can show that 0x86 is the one and only key value that stalls. To do this, it sweeps all 256 key values on each core in turn. The scenarios also show the exact field positions and read-back values, and that the two cores stay independent.

// File: rtl/stall_key_pkg.sv
package stall_key_pkg;
    parameter int  NCORE      = 2;
    parameter int  DATA_W     = 32;
    parameter int  ADDR_W     = 4;
    parameter int  LO_W       = 2;
    parameter int  HI_W       = 6;
    parameter int  KEY_W      = LO_W + HI_W;
    parameter logic [KEY_W-1:0] STALL_KEY = 8'h86;
    parameter int  LO_STRIDE  = 4;
    parameter int  HI_STRIDE  = 8;
    parameter int  RST_BASE   = 16;
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 4'd0;
    parameter logic [ADDR_W-1:0] ADDR_KEYH = 4'd1;

    typedef struct packed {
        logic [NCORE-1:0][LO_W-1:0] lo;
        logic [NCORE-1:0][HI_W-1:0] hi;
        logic [NCORE-1:0]           pulse;
    } key_state_t;
endpackage

// File: rtl/stall_key_regs.sv
module stall_key_regs
    import stall_key_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic [NCORE-1:0][LO_W-1:0]    lo_field,
    output logic [NCORE-1:0][HI_W-1:0]    hi_field,
    output logic [NCORE-1:0]              rst_pulse
);
    key_state_t st_d, st_q;
    logic       hit_ctrl, hit_keyh;

    assign hit_ctrl = wr_en && (addr == ADDR_CTRL);
    assign hit_keyh = wr_en && (addr == ADDR_KEYH);

    always_comb begin
        st_d       = st_q;
        st_d.pulse = '0;
        for (int n = 0; n < NCORE; n++) begin
            if (hit_ctrl) begin
                st_d.lo[n]    = wdata[n*LO_STRIDE +: LO_W];
                st_d.pulse[n] = wdata[RST_BASE + n];
            end
            if (hit_keyh) begin
                st_d.hi[n] = wdata[n*HI_STRIDE +: HI_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        for (int n = 0; n < NCORE; n++) begin
            if (addr == ADDR_CTRL) rdata[n*LO_STRIDE +: LO_W] = st_q.lo[n];
            if (addr == ADDR_KEYH) rdata[n*HI_STRIDE +: HI_W] = st_q.hi[n];
        end
    end

    assign lo_field  = st_q.lo;
    assign hi_field  = st_q.hi;
    assign rst_pulse = st_q.pulse;

    // R8: unmapped writes leave key fields untouched
    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != ADDR_CTRL && addr != ADDR_KEYH) |=>
            ($stable(st_q.lo) && $stable(st_q.hi)))
        else $error("a_r8_unmapped_write");

    // R6: a reset pulse only follows a write to its bit
    generate
        for (genvar g = 0; g < NCORE; g++) begin : g_pchk
            a_r6_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
                rst_pulse[g] |-> $past(wr_en && addr == ADDR_CTRL && wdata[RST_BASE + g]))
                else $error("a_r6_pulse_source");
        end
    endgenerate

    // R6/R7: reset bits never read back as set
    a_r7_rst_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[RST_BASE +: NCORE] == '0)
        else $error("a_r7_rst_bits_zero");
endmodule

// File: rtl/stall_key_match.sv
module stall_key_match
    import stall_key_pkg::*;
(
    input  logic [NCORE-1:0][LO_W-1:0] lo_field,
    input  logic [NCORE-1:0][HI_W-1:0] hi_field,
    output logic [NCORE-1:0]           stall
);
    generate
        for (genvar g = 0; g < NCORE; g++) begin : g_core
            logic [KEY_W-1:0] key_q;
            assign key_q    = {hi_field[g], lo_field[g]};
            assign stall[g] = (key_q == STALL_KEY);
        end
    endgenerate
endmodule

// File: rtl/stall_key_ctrl.sv
module stall_key_ctrl
    import stall_key_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [NCORE-1:0]     stall_o,
    output logic [NCORE-1:0]     core_rst_o
);
    logic [NCORE-1:0][LO_W-1:0] lo_w;
    logic [NCORE-1:0][HI_W-1:0] hi_w;

    stall_key_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .lo_field  (lo_w),
        .hi_field  (hi_w),
        .rst_pulse (core_rst_o)
    );

    stall_key_match i_match (
        .lo_field (lo_w),
        .hi_field (hi_w),
        .stall    (stall_o)
    );

    // R2: stall outputs move only after a write
    a_r2_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(stall_o))
        else $error("a_r2_stall_quiet");

    // R4: clearing either field of a core releases it
    generate
        for (genvar g = 0; g < NCORE; g++) begin : g_rel
            a_r4_release_lo: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && addr == ADDR_CTRL && wdata[g*LO_STRIDE +: LO_W] == '0) |=> !stall_o[g])
                else $error("a_r4_release_lo");
            a_r4_release_hi: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && addr == ADDR_KEYH && wdata[g*HI_STRIDE +: HI_W] == '0) |=> !stall_o[g])
                else $error("a_r4_release_hi");
        end
    endgenerate
endmodule

// File: tb/test_stall_key_ctrl.sv
module test_stall_key_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  stall_o, core_rst_o;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    stall_key_ctrl i_stall_key_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .stall_o(stall_o), .core_rst_o(core_rst_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic [31:0] lo_word(input int core, input logic [1:0] v);
        return 32'(v) << (4 * core);
    endfunction

    function automatic logic [31:0] hi_word(input int core, input logic [5:0] v);
        return 32'(v) << (8 * core);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 stall", 32'(stall_o), 0);
        check("R1 pulse", 32'(core_rst_o), 0);
        rd(4'd0, r); check("R1 ctrl", r, 0);
        rd(4'd1, r); check("R1 keyh", r, 0);

        // R2/R3/R5 exhaustive key sweep per core
        for (int c = 0; c < 2; c++) begin
            for (int k = 0; k < 256; k++) begin
                logic [7:0] kv;
                logic [1:0] exp;
                kv = 8'(k);
                wr(4'd1, hi_word(c, kv[7:2]));
                wr(4'd0, lo_word(c, kv[1:0]));
                exp = '0;
                exp[c] = (kv == 8'h86);
                if (kv == 8'h86) check("R2 key match", 32'(stall_o), 32'(exp));
                else if (kv[1:0] == 2'd2 || kv[7:2] == 6'h21)
                    check("R3 partial key", 32'(stall_o), 32'(exp));
                else check("R3 other key / R5 isolation", 32'(stall_o), 32'(exp));
            end
            wr(4'd0, 0); wr(4'd1, 0);
        end

        // R5 both cores stalled at their own positions
        wr(4'd1, hi_word(0, 6'h21) | hi_word(1, 6'h21));
        wr(4'd0, lo_word(0, 2'd2) | lo_word(1, 2'd2));
        check("R5 both stalled", 32'(stall_o), 3);
        // R4 zero low field of core 1 only
        wr(4'd0, lo_word(0, 2'd2));
        check("R4 release lo", 32'(stall_o), 1);
        wr(4'd0, lo_word(0, 2'd2) | lo_word(1, 2'd2));
        check("R2 restall", 32'(stall_o), 3);
        // R4 zero high field of core 0 only
        wr(4'd1, hi_word(1, 6'h21));
        check("R4 release hi", 32'(stall_o), 2);
        // R9 full-word replace clears core 1 low field
        wr(4'd0, lo_word(0, 2'd1));
        rd(4'd0, r); check("R9 full word", r, 32'h1);
        check("R9 stall", 32'(stall_o), 0);

        // R6/R7 all-ones writes
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd0; wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_en = 1'b0;
        check("R6 pulse high", 32'(core_rst_o), 3);
        rd(4'd0, r); check("R7 ctrl readback", r, 32'h33);
        @(negedge clk);
        check("R6 pulse one cycle", 32'(core_rst_o), 0);
        wr(4'd0, 32'h0001_0000);
        check("R6 core0 pulse", 32'(core_rst_o), 1);
        @(negedge clk);
        wr(4'd0, 32'h0002_0033);
        check("R6 core1 pulse", 32'(core_rst_o), 2);
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1, r); check("R7 keyh readback", r, 32'h3F3F);

        // R8 unmapped addresses
        for (int a = 2; a < 16; a++) begin
            wr(4'(a), 32'hFFFF_FFFF);
            rd(4'(a), r); check("R8 unmapped read", r, 0);
        end
        wr(4'd5, 32'h0);
        rd(4'd0, r); check("R8 ctrl kept", r, 32'h33);
        rd(4'd1, r); check("R8 keyh kept", r, 32'h3F3F);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule